// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

This block collects a wide set of peripheral interrupt request lines and folds them onto a small number of general-purpose event outputs that feed a core event controller. A fixed parameter table assigns each source to one event. An event line is the OR of every source assigned to it whose mask bit is set. Each event output is a latch that records a rising edge on its event line. The latch holds until the core acknowledges the event on a per-event pending input.

Software reaches three registers over a simple single-cycle register bus:
- a per-source mask;
- a read-only per-source status that shows raw request levels;
- a per-source wake-up enable.

A wake-up output is raised whenever a wake-enabled source is asserting, so an idled core can resume. Several sources can share one event. Because of that, edges that arrive while an event is still latched are merged into the latch, and a fresh edge is queued once the core has taken the event.

Top module: `pic_aggregator`

## Requirements
- R1: Event line e is the OR of `src_req[s] & mask[s]` over all sources s that the map table assigns to e. A mask bit of 0 keeps that source from ever setting an event latch.
- R2: A rising edge on an event line sets `evt_pend` for that event after the second rising clock edge. After only the first clock edge the output is still 0.
- R3: Once set, `evt_pend[e]` stays at 1 until `core_ack[e]` is sampled high, even if the event line falls.
- R4: With `core_ack[e]` high at a clock edge, `evt_pend[e]` is 0 after that edge. The exception is a detected rising edge at that same clock edge: it is queued, and `evt_pend[e]` stays 1.
- R5: A rising edge that is detected while `evt_pend[e]` is already set is merged with it. A single acknowledge clears the latch, and no second event follows.
- R6: After an acknowledge, a line that simply stays high does not set the latch again. A new rising edge sets it again.
- R7: A read with `bus_sel` = 1 returns the raw `src_req` value of that clock edge on `bus_rdata` after the edge, whatever the mask holds.
- R8: Reads follow a write to the same register. The mask (`bus_sel` = 0) and the wake enable (`bus_sel` = 2) are read/write and reset to all zeros. Writes with `bus_sel` = 1 change nothing. A read with `bus_sel` = 3 returns 0.
- R9: `wake_req` is 1 one clock after some source with its wake-enable bit set is asserting, and 0 otherwise. The mask has no effect on it.
- R10: In the first cycle after reset, `evt_pend`, `wake_req` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Peripheral interrupt request levels |
| core_ack | input | N_EVT | Per-event pending/acknowledge from the core |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 mask, 1 status, 2 wake enable, 3 reserved |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Registered read data |
| evt_pend | output | N_EVT | Latched event outputs toward the core |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench builds the block with six sources and three events, using the default round-robin map in which source s drives event s mod 3. At this size the bench can sweep every mask value against every request pattern (4096 pairs), and every wake-enable value against every request pattern. Expected event and wake values come from plain arithmetic in the bench. Directed sequences cover the merge, queue and re-arm orderings on a shared event.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int MAX_SRC = 64;
    localparam int MAP_W   = 8;

    typedef enum logic [1:0] {
        SEL_MASK   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_WAKE   = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_cmd_t;

    typedef struct packed {
        logic stage1;
        logic stage2;
        logic pend;
    } edge_state_t;

    typedef logic [MAX_SRC*MAP_W-1:0] src_map_t;

    // Round-robin default map: source i feeds event i mod n_evt.
    function automatic src_map_t rr_map(input int n_evt);
        src_map_t m;
        m = '0;
        for (int i = 0; i < MAX_SRC; i++) begin
            m[i*MAP_W +: MAP_W] = MAP_W'(i % n_evt);
        end
        return m;
    endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic [N_SRC-1:0] wdata,
    input  logic [N_SRC-1:0] src_req,
    output logic [N_SRC-1:0] mask_q,
    output logic [N_SRC-1:0] wen_q,
    output logic [N_SRC-1:0] rdata
);

    logic [N_SRC-1:0] rd_mux;

    always_comb begin
        unique case (cmd.sel)
            SEL_MASK:   rd_mux = mask_q;
            SEL_STATUS: rd_mux = src_req;
            SEL_WAKE:   rd_mux = wen_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            wen_q  <= '0;
            rdata  <= '0;
        end else begin
            if (cmd.wr) begin
                if (cmd.sel == SEL_MASK) mask_q <= wdata;
                if (cmd.sel == SEL_WAKE) wen_q  <= wdata;
            end
            if (cmd.rd) begin
                rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/pic_router.sv
module pic_router
    import pic_pkg::*;
#(
    parameter int       N_SRC   = 16,
    parameter int       N_EVT   = 4,
    parameter src_map_t SRC_MAP = rr_map(4)
) (
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] mask_q,
    output logic [N_EVT-1:0] evt_line
);

    logic [N_SRC-1:0] live;
    assign live = src_req & mask_q;

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        logic [N_SRC-1:0] member;
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign member[s] = (SRC_MAP[s*MAP_W +: MAP_W] == MAP_W'(e));
        end
        assign evt_line[e] = |(live & member);
    end

endmodule

// File: rtl/pic_edge_latch.sv
module pic_edge_latch
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic ack_i,
    output logic rise_o,
    output logic pend_o
);

    edge_state_t st;

    assign rise_o = st.stage1 & ~st.stage2;
    assign pend_o = st.pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.stage1 <= line_i;
            st.stage2 <= st.stage1;
            // a fresh edge wins over a same-cycle acknowledge (queued)
            st.pend   <= (st.pend & ~ack_i) | rise_o;
        end
    end

endmodule

// File: rtl/pic_wake.sv
module pic_wake #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] wen_q,
    output logic             wake_o
);

    always_ff @(posedge clk) begin
        if (rst) wake_o <= 1'b0;
        else     wake_o <= |(src_req & wen_q);
    end

endmodule

// File: rtl/pic_aggregator.sv
module pic_aggregator
    import pic_pkg::*;
#(
    parameter int       N_SRC   = 16,
    parameter int       N_EVT   = 4,
    parameter src_map_t SRC_MAP = rr_map(N_EVT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_EVT-1:0] core_ack,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_sel,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] bus_rdata,
    output logic [N_EVT-1:0] evt_pend,
    output logic             wake_req
);

    bus_cmd_t         cmd;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] wen_q;
    logic [N_EVT-1:0] evt_line;
    logic [N_EVT-1:0] evt_rise;

    assign cmd.rd  = bus_rd;
    assign cmd.wr  = bus_wr;
    assign cmd.sel = reg_sel_e'(bus_sel);

    pic_regs #(.N_SRC(N_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (bus_wdata),
        .src_req (src_req),
        .mask_q  (mask_q),
        .wen_q   (wen_q),
        .rdata   (bus_rdata)
    );

    pic_router #(.N_SRC(N_SRC), .N_EVT(N_EVT), .SRC_MAP(SRC_MAP)) u_router (
        .src_req  (src_req),
        .mask_q   (mask_q),
        .evt_line (evt_line)
    );

    for (genvar e = 0; e < N_EVT; e++) begin : g_latch
        pic_edge_latch u_latch (
            .clk    (clk),
            .rst    (rst),
            .line_i (evt_line[e]),
            .ack_i  (core_ack[e]),
            .rise_o (evt_rise[e]),
            .pend_o (evt_pend[e])
        );
    end

    pic_wake #(.N_SRC(N_SRC)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .src_req (src_req),
        .wen_q   (wen_q),
        .wake_o  (wake_req)
    );

endmodule

// File: rtl/pic_aggregator_chk.sv
module pic_aggregator_chk #(
    parameter int N_SRC = 16,
    parameter int N_EVT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_req,
    input logic [N_EVT-1:0] core_ack,
    input logic             bus_rd,
    input logic [1:0]       bus_sel,
    input logic [N_SRC-1:0] bus_rdata,
    input logic [N_EVT-1:0] evt_pend,
    input logic             wake_req,
    input logic [N_EVT-1:0] evt_line,
    input logic [N_EVT-1:0] evt_rise,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] wen_q
);

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        assert_pend_after_edge_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(evt_pend[e]) |-> $past(evt_line[e], 2));

        assert_pend_holds_R3: assert property (@(posedge clk) disable iff (rst)
            (evt_pend[e] && !core_ack[e]) |=> evt_pend[e]);

        assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
            (core_ack[e] && !evt_rise[e]) |=> !evt_pend[e]);

        assert_ack_queues_R4: assert property (@(posedge clk) disable iff (rst)
            (core_ack[e] && evt_rise[e]) |=> evt_pend[e]);
    end

    assert_status_read_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_rd) && $past(bus_sel) == 2'd1) |-> bus_rdata == $past(src_req));

    assert_regs_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && wen_q == '0));

    assert_wake_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> $past(|(src_req & wen_q)));

    assert_outputs_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (evt_pend == '0 && !wake_req && bus_rdata == '0));

endmodule

bind pic_aggregator pic_aggregator_chk #(.N_SRC(N_SRC), .N_EVT(N_EVT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_req   (src_req),
    .core_ack  (core_ack),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_rdata (bus_rdata),
    .evt_pend  (evt_pend),
    .wake_req  (wake_req),
    .evt_line  (evt_line),
    .evt_rise  (evt_rise),
    .mask_q    (mask_q),
    .wen_q     (wen_q)
);

// File: tb/sim_pic_aggregator.sv
`timescale 1ns/1ps
module sim_pic_aggregator;

    localparam int NS = 6;
    localparam int NE = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] src_req;
    logic [NE-1:0] core_ack;
    logic          bus_rd;
    logic          bus_wr;
    logic [1:0]    bus_sel;
    logic [NS-1:0] bus_wdata;
    logic [NS-1:0] bus_rdata;
    logic [NE-1:0] evt_pend;
    logic          wake_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pic_aggregator #(.N_SRC(NS), .N_EVT(NE)) u0 (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .core_ack  (core_ack),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pend  (evt_pend),
        .wake_req  (wake_req)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [NS-1:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [NS-1:0] d);
        bus_rd = 1'b1; bus_sel = sel;
        tick(1);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // event e collects sources s with s mod NE == e
    function automatic logic [NE-1:0] exp_pend(input logic [NS-1:0] r, input logic [NS-1:0] m);
        logic [NE-1:0] p;
        p = '0;
        for (int s = 0; s < NS; s++) begin
            if (r[s] && m[s]) p[s % NE] = 1'b1;
        end
        return p;
    endfunction

    task automatic ack_all();
        core_ack = '1;
        tick(1);
        core_ack = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [NS-1:0] rd;
        rst = 1'b1; src_req = '0; core_ack = '0;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_sel = 2'd0; bus_wdata = '0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R10 reset state
        check("R10 pend", int'(evt_pend), 0);
        check("R10 wake", int'(wake_req), 0);
        check("R10 rdata", int'(bus_rdata), 0);
        bus_read(2'd0, rd); check("R8 mask reset", int'(rd), 0);
        bus_read(2'd2, rd); check("R8 wen reset", int'(rd), 0);

        // R1 / R2 exhaustive mask x request sweep
        for (int m = 0; m < 64; m++) begin
            bus_write(2'd0, NS'(m));
            for (int r = 0; r < 64; r++) begin
                src_req = NS'(r);
                tick(1);
                check("R2 not after first edge", int'(evt_pend), 0);
                tick(1);
                check("R1 routed event", int'(evt_pend), int'(exp_pend(NS'(r), NS'(m))));
                src_req = '0;
                ack_all();
                tick(2);
                check("R4 cleared by ack", int'(evt_pend), 0);
            end
        end

        // R7 status is raw regardless of mask, R8 read-back
        bus_write(2'd0, '0);
        for (int r = 0; r < 64; r++) begin
            src_req = NS'(r);
            bus_read(2'd1, rd);
            check("R7 status", int'(rd), r);
        end
        src_req = '0;
        tick(2);
        ack_all();

        // R9 wake sweep with mask at zero
        for (int w = 0; w < 64; w++) begin
            bus_write(2'd2, NS'(w));
            bus_read(2'd2, rd);
            check("R8 wen readback", int'(rd), w);
            for (int r = 0; r < 64; r++) begin
                src_req = NS'(r);
                tick(1);
                check("R9 wake", int'(wake_req), int'(|(NS'(r) & NS'(w))));
            end
            src_req = '0;
            tick(1);
        end
        check("R1 mask zero keeps events clear", int'(evt_pend), 0);
        bus_write(2'd2, '0);

        // R8 status writes ignored, reserved reads zero
        bus_write(2'd0, 6'h15);
        bus_write(2'd2, 6'h0a);
        bus_write(2'd1, 6'h3f);
        bus_read(2'd0, rd); check("R8 mask after status write", int'(rd), 'h15);
        bus_read(2'd2, rd); check("R8 wen after status write", int'(rd), 'h0a);
        bus_read(2'd3, rd); check("R8 reserved", int'(rd), 0);
        bus_write(2'd2, '0);

        // directed sequences on event 0 (sources 0 and 3)
        bus_write(2'd0, '1);
        tick(2);
        // R3 hold after line falls
        src_req = 6'b000001;
        tick(2);
        check("R3 set", int'(evt_pend), 1);
        src_req = '0;
        tick(4);
        check("R3 held without ack", int'(evt_pend), 1);
        core_ack = 3'b001;
        tick(1);
        core_ack = '0;
        check("R4 ack clears", int'(evt_pend), 0);
        tick(1);
        check("R4 stays clear", int'(evt_pend), 0);

        // R5 merge: second edge (other source) while still latched
        src_req = 6'b000001;
        tick(2);
        src_req = '0;
        tick(2);
        src_req = 6'b001000;
        tick(2);
        check("R5 still one latch", int'(evt_pend), 1);
        core_ack = 3'b001;
        tick(1);
        core_ack = '0;
        tick(3);
        check("R5 merged edge not replayed", int'(evt_pend), 0);

        // R6 level high after ack does not re-set; new edge does
        check("R6 level no re-set", int'(evt_pend), 0);
        src_req = '0;
        tick(2);
        src_req = 6'b001000;
        tick(2);
        check("R6 re-armed", int'(evt_pend), 1);
        src_req = '0;
        tick(2);
        ack_all();

        // R4 queue: rise detected at the same edge as the ack
        src_req = 6'b000001;
        tick(2);
        src_req = '0;
        tick(2);
        check("R4 pend before queue test", int'(evt_pend), 1);
        src_req = 6'b000001;
        tick(1);
        core_ack = 3'b001;
        tick(1);
        core_ack = '0;
        check("R4 queued edge", int'(evt_pend), 1);
        tick(2);
        check("R4 queued edge held", int'(evt_pend), 1);
        src_req = '0;
        ack_all();
        tick(1);
        check("R4 final clear", int'(evt_pend), 0);

        summary();
    end

endmodule